// File: doc/BRIEF.md
# Coherence Invalidate Queue

This block sits between the coherence interconnect and the tag array of one core's private cache. The interconnect sends invalidate messages, each carrying a line address, over a valid/ready channel. The block takes each message, acknowledges it on the following cycle and stores the address in a small first-in first-out queue. Nothing is written to the cache tags at that point. Queued addresses go to the tag array later, through a tag-invalidate port that shares tag bandwidth with the core's own lookups.

The core's load path does not search the queue. A lookup can therefore hit a line whose invalidate is still waiting. A read barrier closes that gap. When the core raises a barrier, every entry that was already queued at that moment is applied. Core lookups lose the tag port until this is done, and then a one-cycle completion pulse is given. Invalidates that arrive during the drain are still accepted. The barrier does not wait for them.

The tag array matches each applied address and clears the valid bit of the matching line. An address that matches no line has no effect there.

Top module: `invalidate_queue`

## Requirements
- R1: After reset, `invReady` is 1, and `invAck`, `tagInvValid` and `barrierDone` are 0.
- R2: A message is accepted in a cycle where `invValid` and `invReady` are both 1. `invAck` is 1 in exactly the cycle after each acceptance.
- R3: The acknowledge does not wait for the invalidate to reach the tags. An accepted message is acknowledged the next cycle even while core lookups hold the tag port.
- R4: Queued addresses appear on `tagInvAddr` in the order they were accepted. Each address is presented once, in a cycle with `tagInvValid` = 1.
- R5: `tagInvValid` is 0 whenever the queue is empty. It is also 0 whenever `lookupValid` is 1, unless a barrier is draining entries.
- R6: If the queue holds at least one entry and `lookupValid` is 0, `tagInvValid` is 1.
- R7: When a barrier is raised (`barrierReq` = 1 with no barrier pending), the block applies every entry that was queued in that cycle, regardless of `lookupValid`. It then pulses `barrierDone` for one cycle. With an empty queue, the pulse comes in the cycle after the request.
- R8: Messages accepted while a barrier is pending are still acknowledged. They do not delay `barrierDone`.
- R9: `barrierReq` has no effect while a barrier is pending.
- R10: The queue holds DEPTH entries (default 8). While it is full, `invReady` is 0 and no new message is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| invValid | input | 1 | Invalidate message offered by the interconnect |
| invAddr | input | ADDR_W | Line address of the offered message |
| invReady | output | 1 | Queue has space; message accepted when valid and ready |
| invAck | output | 1 | Acknowledge, one cycle after acceptance |
| lookupValid | input | 1 | Core lookup using the tag port this cycle |
| tagInvValid | output | 1 | Apply the head invalidate to the tags this cycle |
| tagInvAddr | output | ADDR_W | Line address to invalidate |
| barrierReq | input | 1 | Read-barrier request |
| barrierDone | output | 1 | One-cycle pulse when the barrier's entries are applied |

## Verification
The bench runs a cycle-accurate queue model alongside the design and compares every output in every cycle.

Directed patterns each isolate one property:
- Lookups held high while the queue fills. This separates the acknowledge from application and exposes the full boundary.
- Lookups dropped. This shows that idle tag cycles drain the queue in arrival order.
- A barrier on an empty queue. This fixes the minimum completion latency.
- A barrier raised under constant lookups while new messages keep arriving and the request is repeated. This checks that only the snapshot entries are waited for and that the repeated request is ignored.

A long random phase then mixes message, lookup and barrier rates, including back-to-back push and pop at the full and empty edges.

// File: rtl/invq_pkg.sv
package invq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } queueStrobes_t;
endpackage

// File: rtl/invq_store.sv
module invq_store
  import invq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  queueStrobes_t     strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] headAddr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) slots[wrPtr] <= wrAddr;
  end

  assign headAddr = slots[rdPtr];
endmodule

// File: rtl/invq_ctrl.sv
module invq_ctrl
  import invq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          invValid,
  input  logic          lookupValid,
  input  logic          barrierReq,
  output logic          invReady,
  output logic          invAck,
  output logic          tagInvValid,
  output logic          barrierDone,
  output logic          drainPending,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  output queueStrobes_t strobes
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count, remaining;
  logic          pending, drainForce, push, pop;

  assign invReady    = (count < CW'(DEPTH));
  assign push        = invValid & invReady;
  assign drainForce  = pending && (remaining != '0);
  assign pop         = (count != '0) && (!lookupValid || drainForce);
  assign tagInvValid = pop;
  assign barrierDone = pending && (remaining == '0);

  assign strobes.push = push;
  assign strobes.pop  = pop;
  assign occupancy    = count;
  assign drainPending = drainForce;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      invAck    <= 1'b0;
      pending   <= 1'b0;
      remaining <= '0;
    end else begin
      count  <= count + CW'(push) - CW'(pop);
      invAck <= push;
      if (pending) begin
        if (remaining == '0) pending <= 1'b0;
        else if (pop)        remaining <= remaining - 1'b1;
      end else if (barrierReq) begin
        pending   <= 1'b1;
        remaining <= count - CW'(pop);
      end
    end
  end
endmodule

// File: rtl/invalidate_queue.sv
module invalidate_queue
  import invq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invAddr,
  output logic              invReady,
  output logic              invAck,
  input  logic              lookupValid,
  output logic              tagInvValid,
  output logic [ADDR_W-1:0] tagInvAddr,
  input  logic              barrierReq,
  output logic              barrierDone
);
  localparam int CW = $clog2(DEPTH + 1);

  queueStrobes_t strobes;
  logic [CW-1:0] occupancy;
  logic          drainPending;

  invq_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .invValid(invValid), .lookupValid(lookupValid),
    .barrierReq(barrierReq), .invReady(invReady), .invAck(invAck),
    .tagInvValid(tagInvValid), .barrierDone(barrierDone),
    .drainPending(drainPending), .occupancy(occupancy), .strobes(strobes)
  );

  invq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) store (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrAddr(invAddr), .headAddr(tagInvAddr)
  );
endmodule

// File: rtl/invalidate_queue_checker.sv
module invalidate_queue_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          invValid,
  input logic          invReady,
  input logic          invAck,
  input logic          lookupValid,
  input logic          tagInvValid,
  input logic          barrierDone,
  input logic          drainPending,
  input logic [CW-1:0] occupancy
);
  a_r2_ack_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    invAck |-> $past(invValid && invReady));

  a_r3_accept_gets_ack: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && invReady) |=> invAck);

  a_r5_lookup_wins: assert property (@(posedge clk) disable iff (!rstN)
    (tagInvValid && lookupValid) |-> drainPending);

  a_r5_empty_idle: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == '0) |-> !tagInvValid);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    barrierDone |=> !barrierDone);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == CW'(DEPTH)) |-> !invReady);
endmodule

bind invalidate_queue invalidate_queue_checker #(.DEPTH(DEPTH), .CW(CW)) chk (
  .clk(clk), .rstN(rstN), .invValid(invValid), .invReady(invReady),
  .invAck(invAck), .lookupValid(lookupValid), .tagInvValid(tagInvValid),
  .barrierDone(barrierDone), .drainPending(drainPending), .occupancy(occupancy)
);

// File: tb/invalidate_queue_test.sv
`timescale 1ns/1ps
module invalidate_queue_test;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;

  logic clk = 0, rstN = 0;
  logic invValid = 0, lookupValid = 0, barrierReq = 0;
  logic [ADDR_W-1:0] invAddr = '0;
  logic invReady, invAck, tagInvValid, barrierDone;
  logic [ADDR_W-1:0] tagInvAddr;

  invalidate_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .invValid(invValid), .invAddr(invAddr),
    .invReady(invReady), .invAck(invAck), .lookupValid(lookupValid),
    .tagInvValid(tagInvValid), .tagInvAddr(tagInvAddr),
    .barrierReq(barrierReq), .barrierDone(barrierDone)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [ADDR_W-1:0] mq[$];
  bit mAck = 0, mPend = 0;
  int mRem = 0;
  int doneSeen = 0;

  task automatic check(string tag, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit expApply(bit lk);
    return (mq.size() != 0) && (!lk || (mPend && mRem != 0));
  endfunction

  task automatic step(bit v, logic [ADDR_W-1:0] a, bit lk, bit br, string tag);
    bit eReady, ePush, eApply, eDone;
    int oldSize;
    @(negedge clk);
    invValid = v; invAddr = a; lookupValid = lk; barrierReq = br;
    #1;
    eReady = (mq.size() < DEPTH);
    ePush  = v && eReady;
    eApply = expApply(lk);
    eDone  = mPend && (mRem == 0);
    check({tag, " R10 ready"}, invReady, eReady);
    check({tag, " R2 ack"}, invAck, mAck);
    check({tag, " R5/R6 apply"}, tagInvValid, eApply);
    check({tag, " R7 done"}, barrierDone, eDone);
    if (eApply) check({tag, " R4 order"}, tagInvAddr, mq[0]);
    if (eDone) doneSeen++;
    oldSize = mq.size();
    mAck = ePush;
    if (mPend) begin
      if (mRem == 0) mPend = 0;
      else if (eApply) mRem--;
    end else if (br) begin
      mPend = 1;
      mRem = oldSize - (eApply ? 1 : 0);
    end
    if (eApply) void'(mq.pop_front());
    if (ePush) mq.push_back(a);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1: reset state
    check("R1 ready", invReady, 1'b1);
    check("R1 ack", invAck, 1'b0);
    check("R1 apply", tagInvValid, 1'b0);
    check("R1 done", barrierDone, 1'b0);

    // R3 and R10: fill with lookups holding the port; ack arrives, ready drops
    for (int i = 0; i < 11; i++) step(1, 32'h100 + i, 1, 0, "R3");
    check("R10 full ready", invReady, 1'b0);

    // R6 and R4: idle tag port drains in order
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, "R6");

    // R7: barrier on an empty queue completes the next cycle
    doneSeen = 0;
    step(0, 0, 1, 1, "R7 empty");
    step(0, 0, 1, 0, "R7 empty");
    check("R7 empty latency", doneSeen, 1);
    step(0, 0, 1, 0, "R7 empty");

    // R8 and R9: barrier under constant lookups, new arrivals and repeated request
    for (int i = 0; i < 5; i++) step(1, 32'h200 + i, 1, 0, "R8 fill");
    doneSeen = 0;
    step(1, 32'h300, 1, 1, "R8 raise");
    for (int i = 0; i < 12; i++) step(1, 32'h301 + i, 1, (i % 3 == 0), "R9 drain");
    check("R8 done once", doneSeen, 1);
    check("R8 arrivals kept", mq.size() > 0, 1'b1);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, "R4 flush");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int mode = (i / 500) % 4;
      bit v  = ($urandom % 4) < (mode == 0 ? 3 : mode == 1 ? 1 : 2);
      bit lk = ($urandom % 4) < (mode == 2 ? 3 : 2);
      bit br = ($urandom % 16) == 0;
      step(v, $urandom, lk, br, "random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule